// File: doc/BRIEF.md
# Per-Block Access Protection Arbiter

This block sits between a serial-bus protocol engine and a nonvolatile array. It rules on every bus access at the moment of its acknowledge: whether the byte or read address phase gets an ACK, and whether a nonvolatile write cycle starts. The array is split into eight blocks. Each block has a 2-bit permission field. A ninth field guards the tail of the protection page and the ID page.

Each block also owns a volatile sticky bit. Once software clears it, the matching permission byte is frozen. Writes to a frozen byte are still acknowledged but have no effect. A write-protect pin refuses all data writes but still lets pointer-setting writes through. A sticky-reset pin drives every sticky bit back to 1.

The protocol engine presents the latched target (array block, or offset in the protection/ID window), the access kind and the data byte. The decision is combinational and the engine samples it at its ACK clock. A one-cycle `acc_valid` strobe commits any state change and qualifies the write-cycle and sticky-clear strobes.

Top module: `blkperm_arbiter`

## Requirements
- R1: After `rst_n` is released, every permission field holds `INIT_PERM` (default 2'b11) and every sticky bit is 1. Protection-window offset k (0..7) reads back as {sticky[k], 5'b0, field[k]}, offset 08h reads as {6'b0, guard field}, and any other target reads back 8'h00.
- R2: Permission codes: bit 1 clear (00, 01) means no access, 10 means read only, 11 means read and write. For an array block (`tgt_page`=0, block `tgt_blk`), a read (`acc_op`=2'b10) is acknowledged only when bit 1 is set. A data write (`acc_op`=2'b01) is acknowledged and starts a write cycle only for code 11.
- R3: A pointer-setting access (`acc_op`=2'b00) is always acknowledged and never starts a write cycle. A refused data write gives `ack`=0 and `start_wr`=0. Code 2'b11 of `acc_op` is reserved and gives `ack`=0 with no action.
- R4: A read of an array block or guarded region whose field is 00 or 01 gets `ack`=0.
- R5: While `wp` is 1, every data write gets `ack`=0 and `start_wr`=0, and no field or sticky bit changes. Pointer-setting accesses and reads behave as with `wp`=0.
- R6: Every sticky bit reads as 1 while `stk_rst_n` is 0, and it is 1 on the first cycle after `stk_rst_n` returns to 1. No sticky bit clears while `stk_rst_n` is 0.
- R7: A sticky bit changes from 1 to 0 only through an accepted data write to its offset (0..7) with data bit 7 at 0. That write pulses `sticky_clr[k]` for one cycle. Data bit 7 at 1, reads, and bus writes can never set a sticky bit back to 1.
- R8: A data write to offset k (0..7) while sticky[k] is 0 gets `ack`=1 and `start_wr`=0, and field k keeps its value.
- R9: The guard field at offset 08h applies the R2 code to offsets 09h–0Fh (protection page tail) and 10h–1Fh (ID page). Reads of offsets 00h–08h are always acknowledged.
- R10: An accepted data write to offset 00h–08h (`wp`=0, byte not frozen) gets `ack`=1 and `start_wr`=1, and loads data bits [1:0] into that field on the strobe's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| wp | input | 1 | Write protect, high refuses all data writes |
| stk_rst_n | input | 1 | Active-low sticky-bit reset level |
| acc_valid | input | 1 | One-cycle strobe at the ACK point that commits the access |
| acc_op | input | 2 | 00 pointer set, 01 data write, 10 read address phase, 11 reserved |
| tgt_page | input | 1 | 0 array block, 1 protection/ID window |
| tgt_blk | input | 3 | Array block index when `tgt_page`=0 |
| tgt_off | input | 5 | Window offset: 00h–0Fh protection page, 10h–1Fh ID page |
| wdata | input | 8 | Data byte of a data write |
| ack | output | 1 | Combinational ACK decision |
| start_wr | output | 1 | Start nonvolatile write cycle, qualified by `acc_valid` |
| sticky_clr | output | 8 | Per-block strobe: sticky bit being cleared |
| prot_rdata | output | 8 | Readback of the addressed protection register byte |

## Verification
The clocked properties assume that the target, kind, data and `wp` inputs are steady around each rising edge and change only between edges. They also assume that `acc_valid` marks only accesses the engine really commits. The bench drives all inputs on the falling edge and holds them through the next rising edge. It raises `acc_valid` for single cycles. It draws offsets from the full 5-bit window, biased toward the nine register bytes, so that guard-field, frozen-byte and sticky-reset cases keep appearing under random `wp` and `stk_rst_n` levels.

// File: rtl/blkperm_pkg.sv
package blkperm_pkg;

  localparam int unsigned PERM_W = 2;

  typedef enum logic [1:0] {
    OP_PTR   = 2'b00,
    OP_WDATA = 2'b01,
    OP_READ  = 2'b10,
    OP_RSVD  = 2'b11
  } acc_op_e;

  // bit 1 gates any access at all
  function automatic logic perm_rd_ok(input logic [PERM_W-1:0] code);
    return code[1];
  endfunction

  // writing needs both bits
  function automatic logic perm_wr_ok(input logic [PERM_W-1:0] code);
    return code[1] & code[0];
  endfunction

endpackage

// File: rtl/blkperm_sticky.sv
module blkperm_sticky #(
  parameter int unsigned NBLK = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stk_rst_n,
  input  logic [NBLK-1:0] clr_req,
  output logic [NBLK-1:0] sticky_q,
  output logic [NBLK-1:0] sticky_eff
);

  for (genvar i = 0; i < NBLK; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              sticky_q[i] <= 1'b1;
      else if (!stk_rst_n)     sticky_q[i] <= 1'b1;
      else if (clr_req[i])     sticky_q[i] <= 1'b0;
    end

    // forced high for the whole time the reset pin is held low
    assign sticky_eff[i] = sticky_q[i] | ~stk_rst_n;

    // R7: the serial side can only lower the bit
    assert_sticky_one_way_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sticky_q[i] && stk_rst_n) |=> !sticky_q[i]);

    // R6: pin low brings the bit back to 1
    assert_sticky_pin_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !stk_rst_n |=> sticky_q[i]);
  end

endmodule

// File: rtl/blkperm_fields.sv
module blkperm_fields
  import blkperm_pkg::*;
#(
  parameter int unsigned NBLK  = 8,
  parameter int unsigned NFLD  = NBLK + 1,
  parameter int unsigned FIDXW = $clog2(NFLD),
  parameter logic [NFLD*PERM_W-1:0] INIT_PERM = '1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         upd_en,
  input  logic [FIDXW-1:0]             upd_idx,
  input  logic [PERM_W-1:0]            upd_val,
  output logic [NFLD-1:0][PERM_W-1:0]  perm_q
);

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        perm_q[i] <= INIT_PERM[i*PERM_W +: PERM_W];
      else if (upd_en && (upd_idx == FIDXW'(i)))
        perm_q[i] <= upd_val;
    end
  end

endmodule

// File: rtl/blkperm_decide.sv
module blkperm_decide
  import blkperm_pkg::*;
#(
  parameter int unsigned NBLK  = 8,
  parameter int unsigned NFLD  = NBLK + 1,
  parameter int unsigned BLKW  = $clog2(NBLK),
  parameter int unsigned FIDXW = $clog2(NFLD),
  parameter int unsigned OFFW  = 5
) (
  input  logic                         tgt_page,
  input  logic [BLKW-1:0]              tgt_blk,
  input  logic [OFFW-1:0]              tgt_off,
  input  logic [1:0]                   acc_op,
  input  logic                         wp,
  input  logic [NFLD-1:0][PERM_W-1:0]  perm_q,
  input  logic [NBLK-1:0]              sticky_eff,
  output logic                         ack,
  output logic                         commit,
  output logic                         discard,
  output logic                         reg_hit,
  output logic                         frz_hit,
  output logic [FIDXW-1:0]             reg_idx
);

  logic [PERM_W-1:0] region_perm;
  logic              byte_frozen;
  acc_op_e           op;

  assign op      = acc_op_e'(acc_op);
  assign reg_hit = tgt_page && (tgt_off <= OFFW'(NBLK));
  assign frz_hit = tgt_page && (tgt_off <  OFFW'(NBLK));
  assign reg_idx = tgt_off[FIDXW-1:0];

  // array blocks use their own field, the guarded window uses the last one
  assign region_perm = tgt_page ? perm_q[NBLK] : perm_q[tgt_blk];
  assign byte_frozen = frz_hit && !sticky_eff[tgt_off[BLKW-1:0]];

  always_comb begin
    ack     = 1'b0;
    commit  = 1'b0;
    discard = 1'b0;
    unique case (op)
      OP_PTR:  ack = 1'b1;
      OP_READ: ack = reg_hit | perm_rd_ok(region_perm);
      OP_WDATA: begin
        if (wp) begin
          ack = 1'b0;
        end else if (reg_hit) begin
          ack = 1'b1;
          if (byte_frozen) discard = 1'b1;
          else             commit  = 1'b1;
        end else if (perm_wr_ok(region_perm)) begin
          ack    = 1'b1;
          commit = 1'b1;
        end
      end
      default: ack = 1'b0;
    endcase
  end

endmodule

// File: rtl/blkperm_arbiter.sv
module blkperm_arbiter
  import blkperm_pkg::*;
#(
  parameter int unsigned NBLK = 8,
  parameter int unsigned OFFW = 5,
  parameter logic [(NBLK+1)*PERM_W-1:0] INIT_PERM = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wp,
  input  logic            stk_rst_n,
  input  logic            acc_valid,
  input  logic [1:0]      acc_op,
  input  logic            tgt_page,
  input  logic [2:0]      tgt_blk,
  input  logic [OFFW-1:0] tgt_off,
  input  logic [7:0]      wdata,
  output logic            ack,
  output logic            start_wr,
  output logic [NBLK-1:0] sticky_clr,
  output logic [7:0]      prot_rdata
);

  localparam int unsigned NFLD  = NBLK + 1;
  localparam int unsigned BLKW  = $clog2(NBLK);
  localparam int unsigned FIDXW = $clog2(NFLD);

  logic [NFLD-1:0][PERM_W-1:0] perm_q;
  logic [NBLK-1:0]             sticky_q;
  logic [NBLK-1:0]             sticky_eff;
  logic                        dec_commit;
  logic                        dec_discard;
  logic                        dec_reg_hit;
  logic                        dec_frz_hit;
  logic [FIDXW-1:0]            dec_reg_idx;

  // named internal events
  logic                        evt_commit;
  logic                        evt_discard;
  logic                        evt_reg_upd;
  logic [NBLK-1:0]             evt_sticky_clr;
  logic                        unused_wdata_bits;

  assign unused_wdata_bits = ^wdata[6:PERM_W];

  blkperm_decide #(
    .NBLK(NBLK), .NFLD(NFLD), .BLKW(BLKW), .FIDXW(FIDXW), .OFFW(OFFW)
  ) u_decide (
    .tgt_page   (tgt_page),
    .tgt_blk    (tgt_blk[BLKW-1:0]),
    .tgt_off    (tgt_off),
    .acc_op     (acc_op),
    .wp         (wp),
    .perm_q     (perm_q),
    .sticky_eff (sticky_eff),
    .ack        (ack),
    .commit     (dec_commit),
    .discard    (dec_discard),
    .reg_hit    (dec_reg_hit),
    .frz_hit    (dec_frz_hit),
    .reg_idx    (dec_reg_idx)
  );

  assign evt_commit  = acc_valid & dec_commit;
  assign evt_discard = acc_valid & dec_discard;
  assign evt_reg_upd = evt_commit & dec_reg_hit;
  assign start_wr    = evt_commit;

  for (genvar k = 0; k < NBLK; k++) begin : g_clr
    assign evt_sticky_clr[k] = evt_reg_upd && dec_frz_hit && stk_rst_n &&
                               (tgt_off[BLKW-1:0] == BLKW'(k)) && !wdata[7];
  end
  assign sticky_clr = evt_sticky_clr;

  blkperm_fields #(
    .NBLK(NBLK), .NFLD(NFLD), .FIDXW(FIDXW), .INIT_PERM(INIT_PERM)
  ) u_fields (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (evt_reg_upd),
    .upd_idx (dec_reg_idx),
    .upd_val (wdata[PERM_W-1:0]),
    .perm_q  (perm_q)
  );

  blkperm_sticky #(.NBLK(NBLK)) u_sticky (
    .clk        (clk),
    .rst_n      (rst_n),
    .stk_rst_n  (stk_rst_n),
    .clr_req    (evt_sticky_clr),
    .sticky_q   (sticky_q),
    .sticky_eff (sticky_eff)
  );

  // register readback for the protection window bytes 00h..08h
  always_comb begin
    prot_rdata = 8'h00;
    if (dec_frz_hit)
      prot_rdata = {sticky_eff[tgt_off[BLKW-1:0]], 5'b0, perm_q[tgt_off[BLKW-1:0]]};
    else if (dec_reg_hit)
      prot_rdata = {6'b0, perm_q[NBLK]};
  end

  // ---------------- assertions ----------------
  assert_commit_has_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |-> ack);

  assert_ptr_always_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_op == OP_PTR) |-> (ack && !start_wr));

  assert_wp_refuses_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && wp && acc_op == OP_WDATA) |-> (!ack && !start_wr));

  assert_noacc_read_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_op == OP_READ && !tgt_page && !perm_q[tgt_blk[BLKW-1:0]][1])
      |-> !ack);

  assert_discard_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_discard |-> (ack && !start_wr && sticky_clr == '0));

  assert_clr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sticky_clr));

  for (genvar i = 0; i < NBLK; i++) begin : g_chk
    assert_frozen_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sticky_eff[i] |=> $stable(perm_q[i]));

    assert_clr_from_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sticky_clr[i] |-> sticky_q[i]);
  end

endmodule

// File: tb/blkperm_arbiter_bench.sv
`timescale 1ns/1ps
module blkperm_arbiter_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wp = 1'b0;
  logic       stk_rst_n = 1'b1;
  logic       acc_valid = 1'b0;
  logic [1:0] acc_op = 2'b00;
  logic       tgt_page = 1'b0;
  logic [2:0] tgt_blk = 3'd0;
  logic [4:0] tgt_off = 5'd0;
  logic [7:0] wdata = 8'h00;
  logic       ack;
  logic       start_wr;
  logic [7:0] sticky_clr;
  logic [7:0] prot_rdata;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;
  bit          done    = 1'b0;

  // reference state
  logic [1:0] m_perm [0:8];
  logic       m_stk  [0:7];

  always #4 clk = ~clk;

  blkperm_arbiter u_blkperm_arbiter (
    .clk(clk), .rst_n(rst_n), .wp(wp), .stk_rst_n(stk_rst_n),
    .acc_valid(acc_valid), .acc_op(acc_op), .tgt_page(tgt_page),
    .tgt_blk(tgt_blk), .tgt_off(tgt_off), .wdata(wdata),
    .ack(ack), .start_wr(start_wr), .sticky_clr(sticky_clr), .prot_rdata(prot_rdata)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic stk_view(input int k, input logic sn);
    return m_stk[k] | ~sn;
  endfunction

  // permission of the target region
  function automatic logic [1:0] region_code(input logic pg, input logic [2:0] b);
    if (pg) return m_perm[8];
    return m_perm[b];
  endfunction

  // {ack, start} expected
  function automatic logic [1:0] exp_dec(input logic pg, input logic [2:0] b,
      input logic [4:0] off, input logic [1:0] op, input logic w, input logic sn);
    logic regb;
    logic [1:0] c;
    regb = pg && (off < 5'd9);
    c    = region_code(pg, b);
    if (op == 2'b00) return 2'b10;
    if (op == 2'b11) return 2'b00;
    if (op == 2'b10) return {(regb || c == 2'b10 || c == 2'b11), 1'b0};
    if (w) return 2'b00;
    if (regb) begin
      if (off < 5'd8 && !stk_view(int'(off), sn)) return 2'b10;
      return 2'b11;
    end
    if (c == 2'b11) return 2'b11;
    return 2'b00;
  endfunction

  function automatic logic [7:0] exp_rd(input logic pg, input logic [4:0] off,
                                        input logic sn);
    if (!pg || off > 5'd8) return 8'h00;
    if (off == 5'd8) return {6'b0, m_perm[8]};
    return {stk_view(int'(off), sn), 5'b0, m_perm[off]};
  endfunction

  function automatic string pick_tag(input logic pg, input logic [4:0] off,
      input logic [1:0] op, input logic w, input logic sn);
    if (op == 2'b00 || op == 2'b11) return "R3";
    if (op == 2'b10) return (pg && off > 5'd8) ? "R9" : (pg ? "R9" : "R4");
    if (w) return "R5";
    if (pg && off < 5'd8 && !stk_view(int'(off), sn)) return "R8";
    if (pg && off < 5'd9) return "R10";
    if (pg) return "R9";
    return "R2";
  endfunction

  task automatic access(input logic pg, input logic [2:0] b, input logic [4:0] off,
      input logic [1:0] op, input logic [7:0] d, input logic w, input logic sn,
      input logic vld);
    logic [1:0] e;
    logic [7:0] eclr;
    string tg;
    @(negedge clk);
    tgt_page = pg; tgt_blk = b; tgt_off = off; acc_op = op; wdata = d;
    wp = w; stk_rst_n = sn; acc_valid = vld;
    #1;
    e  = exp_dec(pg, b, off, op, w, sn);
    tg = pick_tag(pg, off, op, w, sn);
    eclr = 8'h00;
    if (vld && e[0] && pg && off < 5'd8 && !d[7] && sn) eclr[off[2:0]] = 1'b1;
    chk(tg, "ack", {31'b0, ack}, {31'b0, e[1]});
    chk(tg, "start_wr", {31'b0, start_wr}, {31'b0, e[0] & vld});
    chk("R7", "sticky_clr", {24'b0, sticky_clr}, {24'b0, eclr});
    chk("R1", "prot_rdata", {24'b0, prot_rdata}, {24'b0, exp_rd(pg, off, sn)});
    @(posedge clk);
    if (!sn) begin
      for (int k = 0; k < 8; k++) m_stk[k] = 1'b1;
    end
    if (vld && e[0] && pg && off < 5'd9) begin
      m_perm[off] = d[1:0];
      if (off < 5'd8 && !d[7] && sn) m_stk[off] = 1'b0;
    end
    #1 acc_valid = 1'b0;
  endtask

  // look at one register byte without committing
  task automatic peek(input logic [4:0] off, input logic [7:0] exp, input string tag);
    @(negedge clk);
    acc_valid = 1'b0; tgt_page = 1'b1; tgt_off = off; acc_op = 2'b10;
    #1 chk(tag, "readback", {24'b0, prot_rdata}, {24'b0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    for (int k = 0; k < 9; k++) m_perm[k] = 2'b11;
    for (int k = 0; k < 8; k++) m_stk[k] = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R6: reset state
    for (int k = 0; k < 8; k++) peek(5'(k), 8'h83, "R1");
    peek(5'd8, 8'h03, "R1");
    peek(5'd12, 8'h00, "R1");

    // R10: make block 2 read only, R2 consequences
    access(1, 0, 5'd2, 2'b01, 8'h82, 0, 1, 1);
    peek(5'd2, 8'h82, "R10");
    access(0, 3'd2, 0, 2'b10, 8'h00, 0, 1, 1);   // R2 read ok
    access(0, 3'd2, 0, 2'b01, 8'h55, 0, 1, 1);   // R2/R3 write nack
    access(0, 3'd2, 0, 2'b00, 8'h00, 0, 1, 1);   // R3 pointer ack
    // R4: no access block 5
    access(1, 0, 5'd5, 2'b01, 8'h81, 0, 1, 1);
    access(0, 3'd5, 0, 2'b10, 8'h00, 0, 1, 1);
    // R7 / R8: freeze block 2, then try to change it
    access(1, 0, 5'd2, 2'b01, 8'h02, 0, 1, 1);
    peek(5'd2, 8'h02, "R7");
    access(1, 0, 5'd2, 2'b01, 8'h83, 0, 1, 1);
    peek(5'd2, 8'h02, "R8");
    access(1, 0, 5'd2, 2'b10, 8'h00, 0, 1, 1);   // reading leaves it
    peek(5'd2, 8'h02, "R7");
    // R5: write protect
    access(1, 0, 5'd3, 2'b01, 8'h00, 1, 1, 1);
    peek(5'd3, 8'h83, "R5");
    access(0, 3'd0, 0, 2'b00, 8'h00, 1, 1, 1);
    // R6: sticky reset pin
    access(0, 3'd0, 0, 2'b00, 8'h00, 0, 0, 0);
    peek(5'd2, 8'h82, "R6");
    access(0, 3'd0, 0, 2'b00, 8'h00, 0, 1, 0);
    peek(5'd2, 8'h82, "R6");
    // R9: guard field closes tail and ID page
    access(1, 0, 5'd8, 2'b01, 8'h00, 0, 1, 1);
    access(1, 0, 5'd12, 2'b10, 8'h00, 0, 1, 1);
    access(1, 0, 5'd21, 2'b10, 8'h00, 0, 1, 1);
    access(1, 0, 5'd4, 2'b10, 8'h00, 0, 1, 1);
    access(1, 0, 5'd30, 2'b01, 8'h00, 0, 1, 1);
    access(1, 0, 5'd8, 2'b01, 8'h03, 0, 1, 1);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] off;
      off = ($urandom % 3 != 0) ? 5'($urandom % 9) : 5'($urandom);
      access(1'($urandom), 3'($urandom), off, 2'($urandom), 8'($urandom),
             ($urandom % 5) == 0, ($urandom % 20) != 0, ($urandom % 8) != 0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule